// File: doc/BRIEF.md
# Checkpointed Hierarchical Commit Controller

This block stands in for a large reorder buffer. It keeps a small circular table of checkpoints instead of one entry per instruction. Each dispatched instruction is tagged with the newest open checkpoint, and each checkpoint counts how many of its instructions are still unfinished. Instructions report completion in any order and free their own resources at once. The architectural state advances only one whole checkpoint at a time, oldest first. A checkpoint retires once it is the oldest and its unfinished count has reached zero.

A branch opens a fresh checkpoint. If every table entry is already in use, the branch is folded into the newest checkpoint instead. A recovery request names the checkpoint of the faulting instruction. The block rolls back to that checkpoint, throws away every younger one, and reports the restore together with a snapshot identifier. That identifier stands for the saved register and memory image, which this block does not hold.

Dispatch uses a valid/ready handshake. An instruction is accepted in a cycle where `disp_valid` and `disp_ready` are both high. When ready is low the source must hold the instruction and its branch flag. Completion and recovery inputs are single-cycle strobes that are always accepted. Commit and restore outputs are strobes with no back-pressure.

Top module: `hier_commit_ctrl`

## Requirements
- R1: After reset, only checkpoint index 0 is live, with snapshot identifier 0 and no pending instructions. `disp_ready` is 1, `disp_tag` is 0 for a non-branch, and `cmt_valid` and `rst_valid` are 0.
- R2: A non-branch dispatch is tagged (`disp_tag`) with the newest live checkpoint and adds one to that checkpoint's pending count.
- R3: A branch dispatch with fewer than CKPT_N live checkpoints opens the next index, (newest + 1) mod CKPT_N. The branch is tagged with the new checkpoint. The new checkpoint gets the next snapshot identifier, one above the previously issued identifier (modulo 2^SNAP_W), and starts with a pending count of one.
- R4: A branch dispatch with CKPT_N live checkpoints opens nothing. It is tagged with, and counted in, the newest checkpoint.
- R5: A completion subtracts one from the pending count of the checkpoint it names. A completion naming a checkpoint whose pending count is zero is ignored.
- R6: A dispatch and a completion that hit the same checkpoint in one cycle leave its pending count unchanged.
- R7: When more than one checkpoint is live and the oldest has a pending count of zero, `cmt_valid` is 1 and `cmt_idx`/`cmt_snap` give that checkpoint's index and snapshot. The checkpoint retires at the clock edge. At most one checkpoint commits per cycle, in strictly increasing index order modulo CKPT_N. The newest checkpoint never commits.
- R8: `disp_ready` is 0 when the dispatch would add to a checkpoint whose pending count is already 2^CNT_W-1, so a count never wraps. A branch that opens a new checkpoint is never stalled for this reason.
- R9: One cycle after `rec_valid`, `rst_valid` is 1, `rst_idx` equals the requested `rec_tag`, and `rst_snap` is that checkpoint's snapshot identifier. Checkpoints younger than the target are freed. The target becomes the newest checkpoint with a pending count of zero, and the next non-branch dispatch is tagged with it.
- R10: In a cycle with `rec_valid` high, `disp_ready` is 0 and `cmt_valid` is 0. Completions aimed at checkpoints older than the target are still applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Instruction offered for dispatch |
| disp_branch | input | 1 | Offered instruction is a branch |
| disp_ready | output | 1 | Dispatch accepted this cycle if valid |
| disp_tag | output | $clog2(CKPT_N) | Checkpoint the offered instruction is tagged with |
| cmp_valid | input | 1 | An instruction finished |
| cmp_tag | input | $clog2(CKPT_N) | Checkpoint of the finished instruction |
| rec_valid | input | 1 | Recovery request |
| rec_tag | input | $clog2(CKPT_N) | Checkpoint of the faulting instruction (must be live) |
| rst_valid | output | 1 | Restore strobe |
| rst_idx | output | $clog2(CKPT_N) | Checkpoint restored to |
| rst_snap | output | SNAP_W | Snapshot identifier of the restored checkpoint |
| cmt_valid | output | 1 | Oldest checkpoint commits this cycle |
| cmt_idx | output | $clog2(CKPT_N) | Index of the committing checkpoint |
| cmt_snap | output | SNAP_W | Snapshot identifier of the committing checkpoint |

## Verification
A corrupted pending count cannot be seen directly at the ports. It shows up as a commit strobe that fires too early or never fires. It can also show up as `disp_ready` dropping at the wrong fill level, which is visible as soon as the oldest checkpoint drains or the newest one fills. A wrong head or tail pointer shows up in the same cycle as a wrong `disp_tag` or `cmt_idx`. A wrong snapshot register shows up at the next commit or restore of that entry. The bench therefore compares the ready, tag, commit and restore outputs in every cycle against an independent model. It uses directed sequences to fill a checkpoint to its limit, fill the whole table, and roll back mid-stream.

// File: rtl/hc_pkg.sv
package hc_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_INC   = 2'd1,
    OP_DEC   = 2'd2,
    OP_CLEAR = 2'd3
  } cnt_op_e;
endpackage

// File: rtl/hc_entry.sv
module hc_entry
  import hc_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int SNAP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cnt_op_e           op,
  input  logic              load_snap,
  input  logic [SNAP_W-1:0] snap_in,
  output logic [CNT_W-1:0]  cnt,
  output logic [SNAP_W-1:0] snap
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      snap <= '0;
    end else begin
      unique case (op)
        OP_INC:   cnt <= cnt + CNT_W'(1);
        OP_DEC:   cnt <= cnt - CNT_W'(1);
        OP_CLEAR: cnt <= '0;
        default:  cnt <= cnt;
      endcase
      if (load_snap) snap <= snap_in;
    end
  end

  // R8: an increment is never requested on a saturated counter
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_INC) |-> (cnt != CNT_MAX));

  // R5: an empty counter stays empty unless incremented
  a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && op != OP_INC) |=> (cnt == '0));
endmodule

// File: rtl/hc_ptrs.sv
module hc_ptrs #(
  parameter int CKPT_N = 8,
  parameter int SNAP_W = 8,
  localparam int IDX_W  = $clog2(CKPT_N),
  localparam int LIVE_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              open_fire,
  input  logic              commit,
  input  logic              rec_valid,
  input  logic [IDX_W-1:0]  rec_tag,
  output logic [IDX_W-1:0]  head,
  output logic [IDX_W-1:0]  tail,
  output logic [LIVE_W-1:0] live,
  output logic [SNAP_W-1:0] snap_next
);
  logic [IDX_W-1:0] rec_off;
  assign rec_off = rec_tag - head;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head      <= '0;
      tail      <= '0;
      live      <= LIVE_W'(1);
      snap_next <= SNAP_W'(1);
    end else if (rec_valid) begin
      tail <= rec_tag;
      live <= LIVE_W'(rec_off) + LIVE_W'(1);
    end else begin
      if (open_fire) begin
        tail      <= tail + IDX_W'(1);
        snap_next <= snap_next + SNAP_W'(1);
      end
      if (commit) head <= head + IDX_W'(1);
      live <= live + LIVE_W'(open_fire) - LIVE_W'(commit);
    end
  end

  // R3: opening a checkpoint moves the newest index by one
  a_r3_open_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (open_fire && !rec_valid) |=> (tail == $past(tail) + IDX_W'(1)));

  // R7: each commit moves the oldest index by exactly one
  a_r7_head_step: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !rec_valid) |=> (head == $past(head) + IDX_W'(1)));

  // R4: the live count stays within the table
  a_r4_live_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (live != '0) && (live <= LIVE_W'(CKPT_N)));
endmodule

// File: rtl/hier_commit_ctrl.sv
module hier_commit_ctrl
  import hc_pkg::*;
#(
  parameter int CKPT_N = 8,
  parameter int CNT_W  = 4,
  parameter int SNAP_W = 8,
  localparam int IDX_W  = $clog2(CKPT_N),
  localparam int LIVE_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_valid,
  input  logic              disp_branch,
  output logic              disp_ready,
  output logic [IDX_W-1:0]  disp_tag,
  input  logic              cmp_valid,
  input  logic [IDX_W-1:0]  cmp_tag,
  input  logic              rec_valid,
  input  logic [IDX_W-1:0]  rec_tag,
  output logic              rst_valid,
  output logic [IDX_W-1:0]  rst_idx,
  output logic [SNAP_W-1:0] rst_snap,
  output logic              cmt_valid,
  output logic [IDX_W-1:0]  cmt_idx,
  output logic [SNAP_W-1:0] cmt_snap
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [IDX_W-1:0]  head, tail;
  logic [LIVE_W-1:0] live;
  logic [SNAP_W-1:0] snap_next;
  logic [CNT_W-1:0]  cnt_q  [CKPT_N];
  logic [SNAP_W-1:0] snap_q [CKPT_N];

  logic open_new, fire, open_fire, commit;
  logic [IDX_W-1:0] target, rec_off;

  assign open_new   = disp_valid && disp_branch && (live != LIVE_W'(CKPT_N));
  assign target     = open_new ? tail + IDX_W'(1) : tail;
  assign disp_tag   = target;
  assign disp_ready = !rec_valid && (open_new || (cnt_q[tail] != CNT_MAX));
  assign fire       = disp_valid && disp_ready;
  assign open_fire  = fire && open_new;
  assign commit     = !rec_valid && (live > LIVE_W'(1)) && (cnt_q[head] == '0);
  assign rec_off    = rec_tag - head;

  assign cmt_valid = commit;
  assign cmt_idx   = head;
  assign cmt_snap  = snap_q[head];

  hc_ptrs #(.CKPT_N(CKPT_N), .SNAP_W(SNAP_W)) ptrs_i (
    .clk(clk), .rst_n(rst_n), .open_fire(open_fire), .commit(commit),
    .rec_valid(rec_valid), .rec_tag(rec_tag), .head(head), .tail(tail),
    .live(live), .snap_next(snap_next)
  );

  for (genvar g = 0; g < CKPT_N; g++) begin : g_entry
    logic [IDX_W-1:0] off;
    logic inc, dec, clr;
    cnt_op_e op;

    assign off = IDX_W'(g) - head;
    assign clr = rec_valid && ((IDX_W'(g) == rec_tag) ||
                 ((off > rec_off) && (LIVE_W'(off) < live)));
    assign inc = fire && (target == IDX_W'(g));
    assign dec = cmp_valid && (cmp_tag == IDX_W'(g)) && (cnt_q[g] != '0);

    always_comb begin
      if (clr)              op = OP_CLEAR;
      else if (inc && !dec) op = OP_INC;
      else if (dec && !inc) op = OP_DEC;
      else                  op = OP_HOLD;
    end

    hc_entry #(.CNT_W(CNT_W), .SNAP_W(SNAP_W)) entry_i (
      .clk(clk), .rst_n(rst_n), .op(op),
      .load_snap(open_fire && (target == IDX_W'(g))),
      .snap_in(snap_next), .cnt(cnt_q[g]), .snap(snap_q[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rst_valid <= 1'b0;
      rst_idx   <= '0;
      rst_snap  <= '0;
    end else begin
      rst_valid <= rec_valid;
      if (rec_valid) begin
        rst_idx  <= rec_tag;
        rst_snap <= snap_q[rec_tag];
      end
    end
  end

  // R9: a recovery request yields a restore strobe for the same index
  a_r9_restore: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |=> (rst_valid && rst_idx == $past(rec_tag)));

  // R10: nothing enters or retires while a recovery is taken
  a_r10_quiet_on_recovery: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> (!disp_ready && !cmt_valid));

  // R7: the newest checkpoint is never the one committing
  a_r7_not_newest: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_valid |-> (cmt_idx != tail));
endmodule

// File: tb/hier_commit_ctrl_tb_top.sv
module hier_commit_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CKPT_N = 8;
  localparam int CNT_W  = 4;
  localparam int SNAP_W = 8;
  localparam int IDX_W  = $clog2(CKPT_N);
  localparam int CMAX   = (1 << CNT_W) - 1;
  localparam int WD_CYCLES = 20000;

  logic clk = 1'b0;
  logic rst_n;
  logic disp_valid, disp_branch, disp_ready;
  logic [IDX_W-1:0] disp_tag, cmp_tag, rec_tag, rst_idx, cmt_idx;
  logic cmp_valid, rec_valid, rst_valid, cmt_valid;
  logic [SNAP_W-1:0] rst_snap, cmt_snap;

  always #(CLK_PERIOD/2) clk = ~clk;

  hier_commit_ctrl #(.CKPT_N(CKPT_N), .CNT_W(CNT_W), .SNAP_W(SNAP_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_branch(disp_branch),
    .disp_ready(disp_ready), .disp_tag(disp_tag), .cmp_valid(cmp_valid),
    .cmp_tag(cmp_tag), .rec_valid(rec_valid), .rec_tag(rec_tag),
    .rst_valid(rst_valid), .rst_idx(rst_idx), .rst_snap(rst_snap),
    .cmt_valid(cmt_valid), .cmt_idx(cmt_idx), .cmt_snap(cmt_snap)
  );

  int n_checks = 0;
  int n_fail   = 0;
  string phase = "init";

  // reference model state
  int m_cnt  [CKPT_N];
  int m_snap [CKPT_N];
  int m_head, m_tail, m_live, m_snext;
  int m_rv, m_ridx, m_rsnap;

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s [%s] actual=%0d expected=%0d", req, phase, act, exp);
    end
  endtask

  function automatic int wrap(int v);
    return ((v % CKPT_N) + CKPT_N) % CKPT_N;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < CKPT_N; i++) begin m_cnt[i] = 0; m_snap[i] = 0; end
    m_head = 0; m_tail = 0; m_live = 1; m_snext = 1;
    m_rv = 0; m_ridx = 0; m_rsnap = 0;
  endtask

  // one clock: drive, check against model, advance model
  task automatic step(bit dv, bit db, bit cv, int ct, bit rv, int rt);
    bit open, rdy, fire, cmt;
    int tgt, roff;
    @(negedge clk);
    disp_valid = dv; disp_branch = db; cmp_valid = cv; cmp_tag = IDX_W'(ct);
    rec_valid = rv; rec_tag = IDX_W'(rt);
    #1;
    open = dv && db && (m_live != CKPT_N);
    tgt  = open ? wrap(m_tail + 1) : m_tail;
    rdy  = !rv && (open || m_cnt[m_tail] != CMAX);
    fire = dv && rdy;
    cmt  = !rv && m_live > 1 && m_cnt[m_head] == 0;
    check("R8/R10 disp_ready", int'(disp_ready), int'(rdy));
    if (dv) check(db ? (open ? "R3 branch tag" : "R4 merged tag") : "R2 tag",
                  int'(disp_tag), tgt);
    check("R7/R10 cmt_valid", int'(cmt_valid), int'(cmt));
    if (cmt) begin
      check("R7 cmt_idx", int'(cmt_idx), m_head);
      check("R7 cmt_snap", int'(cmt_snap), m_snap[m_head]);
    end
    check("R9 rst_valid", int'(rst_valid), m_rv);
    if (m_rv != 0) begin
      check("R9 rst_idx", int'(rst_idx), m_ridx);
      check("R9 rst_snap", int'(rst_snap), m_rsnap);
    end
    // advance model
    m_rv = rv;
    if (rv) begin
      m_ridx = rt; m_rsnap = m_snap[rt];
      roff = wrap(rt - m_head);
      if (cv && m_cnt[ct] > 0 && wrap(ct - m_head) < roff) m_cnt[ct]--;
      for (int k = roff; k < m_live; k++) m_cnt[wrap(m_head + k)] = 0;
      m_tail = rt; m_live = roff + 1;
    end else begin
      bit dec_ok;
      dec_ok = cv && m_cnt[ct] > 0;
      if (fire && dec_ok && ct == tgt) begin
        // R6: same entry, net unchanged
      end else begin
        if (dec_ok) m_cnt[ct]--;
        if (fire) m_cnt[tgt]++;
      end
      if (fire && open) begin
        m_snap[tgt] = m_snext; m_snext = (m_snext + 1) % (1 << SNAP_W);
        m_tail = tgt; m_live++;
      end
      if (cmt) begin m_head = wrap(m_head + 1); m_live--; end
    end
  endtask

  task automatic finish_run();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    disp_valid = 0; disp_branch = 0; cmp_valid = 0; cmp_tag = '0;
    rec_valid = 0; rec_tag = '0;
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    phase = "R1 reset";
    check("R1 disp_ready", int'(disp_ready), 1);
    check("R1 disp_tag", int'(disp_tag), 0);
    check("R1 cmt_valid", int'(cmt_valid), 0);
    check("R1 rst_valid", int'(rst_valid), 0);

    // R8: fill checkpoint 0 to saturation, then one more must stall
    phase = "R8 saturate";
    for (int i = 0; i < CMAX - 1; i++) step(1, 0, 0, 0, 0, 0);
    // R6: same-cycle dispatch and completion on the same entry
    phase = "R6 same-cycle";
    for (int i = 0; i < 5; i++) step(1, 0, 1, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0);
    phase = "R8 stall";
    step(1, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0);
    // R3: branch still opens a checkpoint while the newest is saturated
    phase = "R3 open";
    step(1, 1, 0, 0, 0, 0);
    // R7: drain checkpoint 0 and watch it commit
    phase = "R7 drain";
    for (int i = 0; i < CMAX; i++) step(0, 0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    // R5: completion on an empty entry is ignored
    phase = "R5 empty";
    step(0, 0, 1, 5, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    // R4: fill the table with branches, then merge
    phase = "R4 full";
    for (int i = 0; i < CKPT_N + 2; i++) step(1, 1, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0);
    // R9: roll back into the middle of the table
    phase = "R9 recover";
    step(0, 0, 0, 0, 1, wrap(m_head + 2));
    step(1, 0, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0, 0);
    // R10: completion to an older entry during recovery is applied
    phase = "R10 recover";
    step(0, 0, 1, m_head, 1, wrap(m_head + 1));
    step(0, 0, 0, 0, 0, 0);

    phase = "random";
    for (int c = 0; c < 4000; c++) begin
      bit dv, db, cv, rv;
      int ct, rt;
      dv = ($urandom % 100) < 60;
      db = ($urandom % 100) < 25;
      cv = ($urandom % 100) < 65;
      ct = ($urandom % 10 == 0) ? int'($urandom % CKPT_N)
                                : wrap(m_head + int'($urandom % m_live));
      rv = ($urandom % 100) < 3;
      rt = wrap(m_head + int'($urandom % m_live));
      step(dv, db, cv, ct, rv, rt);
    end
    step(0, 0, 0, 0, 0, 0);
    finish_run();
  end
endmodule